// File: doc/BRIEF.md
# Debug Bus Scan Access Handler

This block sits behind the data-register path of a test access port and turns each completed scan of the debug-bus register into one transaction toward a debug module. The scanned word has three fields: a two-bit command in the low bits, a 32-bit data word above it, and an address on top. When the TAP signals an update, the handler stores the scanned word as its register image. For a read or a write it also issues a request on a valid/ready port. When the matching response comes back, the handler folds the outcome into the image. The TAP captures that image on its next scan.

The low two bits carry a command on the way in and a completion status on the way out. Read data replaces the data field of the same image. An update that arrives while a transaction is still open is discarded, and the handler raises a sticky busy status. That status is cleared only by a separate bus-clear strobe.

Back-pressure rules for the request port: once `req_valid` rises, it stays high with address, data and direction frozen until the cycle in which `req_ready` is sampled high. Exactly one request is in flight at a time. `resp_valid` is a one-cycle pulse from the debug module. It must only arrive after its request has been accepted, and it cannot be stalled.

Top module: `dbs_scan_handler`

## Requirements
- R1: After reset, `image_word` is all zeros (status success, data and address zero) and `req_valid` is low.
- R2: Field layout of `scan_word` and `image_word`: command/status in bits [1:0], data in bits [33:2], address in bits [AW+33:34]. A request carries the address and data fields of the accepted word.
- R3: Command codes are 0 = no operation, 1 = read, 2 = write, 3 = reserved. Read issues a request with `req_write` = 0, and write issues one with `req_write` = 1. Codes 0 and 3 issue no request, and the image becomes the scanned word with status 0.
- R4: Status codes in bits [1:0] of the image are 0 = success, 1 = unused, 2 = failed, 3 = busy. On an accepted update the whole scanned word becomes the image. The status reads 3 from that cycle until the response of a read or write.
- R5: While `req_valid` is high and `req_ready` is low, the request stays valid with address, data and direction unchanged. `req_valid` is only high while a transaction is open.
- R6: A read response without error writes `resp_rdata` into the data field and sets status 0.
- R7: A response with `resp_err` high sets status 2 and leaves the data field as scanned. A write response without error sets status 0.
- R8: An update while a transaction is open is dropped. The address and data fields of the image stay as they were, no new request is made, and status becomes 3.
- R9: After a dropped update, status stays 3 through the pending response and through later updates, which are also dropped. A `bus_clear` pulse ends this state: status returns to 0 if nothing is in flight, and otherwise stays 3 until the response. A `bus_clear` in the same cycle as an update takes effect first, so that update is accepted if nothing is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_pulse | input | 1 | One-cycle strobe: scan register update |
| scan_word | input | AW+34 | Shifted register value, valid with `upd_pulse` |
| bus_clear | input | 1 | One-cycle strobe clearing the sticky busy state |
| image_word | output | AW+34 | Stored image captured by the next scan |
| req_valid | output | 1 | Request to the debug module is valid |
| req_ready | input | 1 | Debug module accepts the request |
| req_addr | output | AW | Request address (AW from 7 to 16) |
| req_wdata | output | 32 | Request write data |
| req_write | output | 1 | 1 = write, 0 = read |
| resp_valid | input | 1 | One-cycle response strobe |
| resp_rdata | input | 32 | Read data returned with the response |
| resp_err | input | 1 | Response reports failure |

## Verification
A corrupted open-transaction flag would show in the cycle after the next update. Either a second request appears while the first is unanswered, or a fresh update is wrongly dropped with status 3. A lost sticky flag would let the status fall back to 0 or 2 at the next response instead of holding 3. A stale direction bit would merge read data into a write's image, or skip the merge for a read, and that shows on the data field in the cycle after the response. Every such fault reaches `image_word` or the request port within two clock cycles of the stimulus that exposes it.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CODE_W = 2;
  localparam int unsigned DATA_LO = CODE_W;
  localparam int unsigned ADDR_LO = CODE_W + DATA_W;

  typedef enum logic [CODE_W-1:0] {
    CMD_NOP   = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_RSVD  = 2'd3
  } cmd_e;

  typedef enum logic [CODE_W-1:0] {
    ST_OK   = 2'd0,
    ST_RSVD = 2'd1,
    ST_FAIL = 2'd2,
    ST_BUSY = 2'd3
  } stat_e;

  function automatic logic is_access(input logic [CODE_W-1:0] code);
    return (code == CMD_READ) || (code == CMD_WRITE);
  endfunction
endpackage

// File: rtl/dbs_field_split.sv
module dbs_field_split
  import dbs_pkg::*;
#(
  parameter int unsigned AW = 10,
  localparam int unsigned SW = AW + ADDR_LO
) (
  input  logic [SW-1:0]     word,
  output logic [AW-1:0]     addr,
  output logic [DATA_W-1:0] data,
  output cmd_e              cmd
);
  assign addr = word[SW-1:ADDR_LO];
  assign data = word[ADDR_LO-1:DATA_LO];
  assign cmd  = cmd_e'(word[CODE_W-1:0]);
endmodule

// File: rtl/dbs_req_port.sv
module dbs_req_port
  import dbs_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [AW-1:0]     issue_addr,
  input  logic [DATA_W-1:0] issue_data,
  input  logic              issue_wr,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [AW-1:0]     req_addr,
  output logic [DATA_W-1:0] req_wdata,
  output logic              req_write,
  input  logic              resp_valid,
  output logic              inflight
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
      req_write <= 1'b0;
      inflight  <= 1'b0;
    end else begin
      if (issue) begin
        req_valid <= 1'b1;
        req_addr  <= issue_addr;
        req_wdata <= issue_data;
        req_write <= issue_wr;
      end else if (req_valid && req_ready) begin
        req_valid <= 1'b0;
      end
      if (issue)           inflight <= 1'b1;
      else if (resp_valid) inflight <= 1'b0;
    end
  end
endmodule

// File: rtl/dbs_image.sv
module dbs_image
  import dbs_pkg::*;
#(
  parameter int unsigned AW = 10,
  localparam int unsigned SW = AW + ADDR_LO
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SW-1:0]     load_word,
  input  logic              drop,
  input  logic              resp_fire,
  input  logic              resp_is_read,
  input  logic              resp_err,
  input  logic [DATA_W-1:0] resp_rdata,
  input  logic              clear,
  input  logic              inflight,
  output logic [SW-1:0]     image_word,
  output logic              sticky
);
  logic [SW-1:0] img_d;
  logic          sticky_d;
  logic          sticky_base;

  assign sticky_base = sticky & ~clear;

  always_comb begin
    img_d    = image_word;
    sticky_d = sticky_base;
    if (load) begin
      img_d = load_word;
      img_d[CODE_W-1:0] = is_access(load_word[CODE_W-1:0]) ? ST_BUSY : ST_OK;
    end else begin
      if (resp_fire) begin
        if (resp_is_read && !resp_err) img_d[ADDR_LO-1:DATA_LO] = resp_rdata;
        img_d[CODE_W-1:0] = sticky_base ? ST_BUSY : (resp_err ? ST_FAIL : ST_OK);
      end else if (clear && !inflight) begin
        img_d[CODE_W-1:0] = ST_OK;
      end
      if (drop) begin
        img_d[CODE_W-1:0] = ST_BUSY;
        sticky_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      image_word <= '0;
      sticky     <= 1'b0;
    end else begin
      image_word <= img_d;
      sticky     <= sticky_d;
    end
  end
endmodule

// File: rtl/dbs_scan_handler.sv
module dbs_scan_handler
  import dbs_pkg::*;
#(
  parameter int unsigned AW = 10,
  localparam int unsigned SW = AW + ADDR_LO
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_pulse,
  input  logic [SW-1:0]     scan_word,
  input  logic              bus_clear,
  output logic [SW-1:0]     image_word,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [AW-1:0]     req_addr,
  output logic [DATA_W-1:0] req_wdata,
  output logic              req_write,
  input  logic              resp_valid,
  input  logic [DATA_W-1:0] resp_rdata,
  input  logic              resp_err
);
  logic [AW-1:0]     f_addr;
  logic [DATA_W-1:0] f_data;
  cmd_e              f_cmd;
  logic              inflight_q;
  logic              sticky_q;
  logic              accept;
  logic              drop;
  logic              issue;
  logic              resp_fire;

  dbs_field_split #(.AW(AW)) u_split (
    .word (scan_word),
    .addr (f_addr),
    .data (f_data),
    .cmd  (f_cmd)
  );

  assign accept    = upd_pulse && !inflight_q && !(sticky_q && !bus_clear);
  assign drop      = upd_pulse && !accept;
  assign issue     = accept && is_access(f_cmd);
  assign resp_fire = resp_valid && inflight_q;

  dbs_req_port #(.AW(AW)) u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (issue),
    .issue_addr (f_addr),
    .issue_data (f_data),
    .issue_wr   (f_cmd == CMD_WRITE),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_write  (req_write),
    .resp_valid (resp_valid),
    .inflight   (inflight_q)
  );

  dbs_image #(.AW(AW)) u_img (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (accept),
    .load_word    (scan_word),
    .drop         (drop),
    .resp_fire    (resp_fire),
    .resp_is_read (!req_write),
    .resp_err     (resp_err),
    .resp_rdata   (resp_rdata),
    .clear        (bus_clear),
    .inflight     (inflight_q),
    .image_word   (image_word),
    .sticky       (sticky_q)
  );
endmodule

// File: rtl/dbs_scan_handler_chk.sv
module dbs_scan_handler_chk #(
  parameter int unsigned AW = 10,
  localparam int unsigned SW = AW + 34
) (
  input logic          clk,
  input logic          rst_n,
  input logic          upd_pulse,
  input logic [SW-1:0] scan_word,
  input logic          bus_clear,
  input logic [SW-1:0] image_word,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic [31:0]   req_wdata,
  input logic          req_write,
  input logic          resp_valid,
  input logic          resp_err,
  input logic          inflight_q,
  input logic          sticky_q
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_wdata) && $stable(req_write)); // R5
  AST_REQ_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> inflight_q); // R5
  AST_INFLIGHT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    inflight_q |-> image_word[1:0] == 2'd3); // R4
  AST_IDLE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse && !inflight_q && (!sticky_q || bus_clear) && (scan_word[1:0] == 2'd0 || scan_word[1:0] == 2'd3)
    |=> !req_valid && image_word == {$past(scan_word[SW-1:2]), 2'd0}); // R3
  AST_DROP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse && inflight_q && !resp_valid |=> image_word[1:0] == 2'd3 && $stable(image_word[SW-1:2])); // R8
  AST_FAIL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && inflight_q && resp_err && !sticky_q && !upd_pulse |=> image_word[1:0] == 2'd2); // R7
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_q && !bus_clear |=> image_word[1:0] == 2'd3); // R9
endmodule

bind dbs_scan_handler dbs_scan_handler_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .upd_pulse  (upd_pulse),
  .scan_word  (scan_word),
  .bus_clear  (bus_clear),
  .image_word (image_word),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .req_wdata  (req_wdata),
  .req_write  (req_write),
  .resp_valid (resp_valid),
  .resp_err   (resp_err),
  .inflight_q (inflight_q),
  .sticky_q   (sticky_q)
);

// File: tb/dbs_scan_handler_test.sv
module dbs_scan_handler_test;
  localparam int unsigned AW = 10;
  localparam int unsigned SW = AW + 34;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          upd_pulse = 1'b0;
  logic [SW-1:0] scan_word = '0;
  logic          bus_clear = 1'b0;
  logic [SW-1:0] image_word;
  logic          req_valid;
  logic          req_ready = 1'b0;
  logic [AW-1:0] req_addr;
  logic [31:0]   req_wdata;
  logic          req_write;
  logic          resp_valid = 1'b0;
  logic [31:0]   resp_rdata = '0;
  logic          resp_err = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dbs_scan_handler #(.AW(AW)) uut (.*);

  typedef struct packed {
    logic [1:0]    op;
    logic [AW-1:0] addr;
    logic [31:0]   wdata;
    logic [31:0]   rdata;
    logic          err;
    logic [1:0]    exp_st;
    logic [31:0]   exp_data;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 10'h011, 32'hAAAA0000, 32'h12345678, 1'b0, 2'd0, 32'h12345678},
    '{2'd2, 10'h022, 32'hCAFEF00D, 32'h0,        1'b0, 2'd0, 32'hCAFEF00D},
    '{2'd1, 10'h07F, 32'h00000005, 32'hFFFFFFFF, 1'b1, 2'd2, 32'h00000005},
    '{2'd2, 10'h155, 32'h80000001, 32'h0,        1'b1, 2'd2, 32'h80000001},
    '{2'd0, 10'h2AA, 32'h0BADC0DE, 32'h0,        1'b0, 2'd0, 32'h0BADC0DE},
    '{2'd3, 10'h001, 32'h00000001, 32'h0,        1'b0, 2'd0, 32'h00000001},
    '{2'd1, 10'h3FF, 32'h5A5A5A5A, 32'h00000000, 1'b0, 2'd0, 32'h00000000}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_upd(input logic [1:0] op, input logic [AW-1:0] a, input logic [31:0] d, input bit clr);
    @(negedge clk);
    scan_word = {a, d, op};
    upd_pulse = 1'b1;
    bus_clear = clr;
    @(negedge clk);
    upd_pulse = 1'b0;
    bus_clear = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    bus_clear = 1'b1;
    @(negedge clk);
    bus_clear = 1'b0;
  endtask

  task automatic serve(input logic [31:0] rd, input logic e);
    @(negedge clk);
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    resp_valid = 1'b1;
    resp_rdata = rd;
    resp_err = e;
    @(negedge clk);
    resp_valid = 1'b0;
    resp_err = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(image_word == '0, "R1 image", 64'(image_word), 64'h0);
    check(req_valid == 1'b0, "R1 req_valid", 64'(req_valid), 64'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      do_upd(VEC[i].op, VEC[i].addr, VEC[i].wdata, 1'b0);
      if (VEC[i].op == 2'd1 || VEC[i].op == 2'd2) begin
        check(req_valid == 1'b1, "R3 request issued", 64'(req_valid), 64'h1);
        check(req_write == (VEC[i].op == 2'd2), "R3 direction", 64'(req_write), 64'(VEC[i].op == 2'd2));
        check(req_addr == VEC[i].addr, "R2 req_addr", 64'(req_addr), 64'(VEC[i].addr));
        check(req_wdata == VEC[i].wdata, "R2 req_wdata", 64'(req_wdata), 64'(VEC[i].wdata));
        check(image_word[1:0] == 2'd3, "R4 in-flight busy", 64'(image_word[1:0]), 64'd3);
        check(image_word[SW-1:34] == VEC[i].addr, "R4 image addr", 64'(image_word[SW-1:34]), 64'(VEC[i].addr));
        serve(VEC[i].rdata, VEC[i].err);
      end else begin
        check(req_valid == 1'b0, "R3 no request", 64'(req_valid), 64'h0);
      end
      check(image_word[1:0] == VEC[i].exp_st, "R6/R7 status", 64'(image_word[1:0]), 64'(VEC[i].exp_st));
      check(image_word[33:2] == VEC[i].exp_data, "R6/R7 data", 64'(image_word[33:2]), 64'(VEC[i].exp_data));
      check(image_word[SW-1:34] == VEC[i].addr, "R2 addr field", 64'(image_word[SW-1:34]), 64'(VEC[i].addr));
      check(req_valid == 1'b0, "R5 request retired", 64'(req_valid), 64'h0);
    end

    // R5 back-pressure
    do_upd(2'd2, 10'h0C3, 32'h13579BDF, 1'b0);
    repeat (3) @(negedge clk);
    check(req_valid == 1'b1, "R5 held valid", 64'(req_valid), 64'h1);
    check(req_wdata == 32'h13579BDF, "R5 held data", 64'(req_wdata), 64'h13579BDF);
    serve(32'h0, 1'b0);
    check(image_word[1:0] == 2'd0, "R7 write ok", 64'(image_word[1:0]), 64'd0);

    // R8 overlap drop
    do_upd(2'd1, 10'h005, 32'h00000100, 1'b0);
    do_upd(2'd2, 10'h009, 32'h00000200, 1'b0);
    check(image_word[SW-1:34] == 10'h005, "R8 addr kept", 64'(image_word[SW-1:34]), 64'h5);
    check(image_word[33:2] == 32'h100, "R8 data kept", 64'(image_word[33:2]), 64'h100);
    check(image_word[1:0] == 2'd3, "R8 busy", 64'(image_word[1:0]), 64'd3);
    check(req_addr == 10'h005 && req_write == 1'b0, "R8 no new request", 64'({req_write, req_addr}), 64'h005);

    // R9 sticky through response and later update
    serve(32'h00000077, 1'b0);
    check(image_word[33:2] == 32'h77, "R6 merge under sticky", 64'(image_word[33:2]), 64'h77);
    check(image_word[1:0] == 2'd3, "R9 sticky after resp", 64'(image_word[1:0]), 64'd3);
    do_upd(2'd0, 10'h00F, 32'h00000300, 1'b0);
    check(image_word[33:2] == 32'h77, "R9 update dropped", 64'(image_word[33:2]), 64'h77);
    check(image_word[1:0] == 2'd3, "R9 still busy", 64'(image_word[1:0]), 64'd3);
    pulse_clear();
    check(image_word[1:0] == 2'd0, "R9 clear idle", 64'(image_word[1:0]), 64'd0);
    do_upd(2'd0, 10'h00F, 32'h00000300, 1'b0);
    check(image_word[33:2] == 32'h300, "R9 accepted after clear", 64'(image_word[33:2]), 64'h300);

    // R9 clear while in flight
    do_upd(2'd1, 10'h030, 32'h0, 1'b0);
    pulse_clear();
    check(image_word[1:0] == 2'd3, "R9 clear in flight", 64'(image_word[1:0]), 64'd3);
    serve(32'h00000042, 1'b0);
    check(image_word[1:0] == 2'd0, "R9 done after clear", 64'(image_word[1:0]), 64'd0);

    // R9 clear coincident with update
    do_upd(2'd1, 10'h031, 32'h0, 1'b0);
    do_upd(2'd1, 10'h032, 32'h0, 1'b0);
    serve(32'h1, 1'b0);
    do_upd(2'd0, 10'h033, 32'h00000444, 1'b1);
    check(image_word[33:2] == 32'h444, "R9 same-cycle clear data", 64'(image_word[33:2]), 64'h444);
    check(image_word[1:0] == 2'd0, "R9 same-cycle clear status", 64'(image_word[1:0]), 64'd0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule